// File: doc/BRIEF.md
# Set-Associative Cache Read and Prefetch Controller

This block is the read side of a small four-way set-associative cache. A CPU presents one request at a time, either a plain read or an operand prefetch. A read that hits returns its word on the next cycle. A prefetch that hits returns nothing. Both kinds of hit make the hit way the most recently used way of its set.

A miss stalls the request port. The controller then picks a victim way and, if that line holds modified data, first hands the whole line to a separate write-back buffer. It then issues one burst request for the 16-byte line. The burst starts at the missed word and wraps around inside the line. On a read miss, the first returned word is forwarded to the CPU while the remaining beats are still arriving. On a prefetch miss, the line is loaded and nothing is returned.

A neighbouring write path, which is not part of this block, reports lines it has modified through a mark port. This is how entries become dirty.

Top module: `cache_read_ctrl`

## Requirements
- R1: A read request that hits returns the addressed word on `rsp_data` with `rsp_valid` high for exactly one cycle. That cycle is the one after the accepting clock edge. No external request is issued.
- R2: Any hit makes the hit way the most recently used way of its set. The relative order of the other ways in the set is kept.
- R3: On a miss, `req_ready` drops after the accepting edge and stays low until the line is complete. Exactly one burst request is issued per miss. Its address is the missed address with bits [1:0] cleared. Address layout: bits [3:2] select the word in the line, bits [7:4] select the set, and bits [31:8] form the tag.
- R4: The four burst beats are written to word offsets starting at the missed offset and increasing modulo 4. For example, a miss at offset 3 fills offsets 3, 0, 1, 2. Afterwards every word of the line reads back as its own memory value.
- R5: On a read miss, `rsp_valid` rises in the cycle after the first beat is taken, carrying that beat's data. It does not wait for the remaining three beats.
- R6: When the last beat is taken, the entry becomes valid with the new tag, its dirty flag is cleared, and its way becomes the most recently used way.
- R7: A prefetch that hits returns no response and issues no burst. It still makes the hit way the most recently used way.
- R8: A prefetch that misses performs the same refill as a read miss but never raises `rsp_valid`.
- R9: The victim is the lowest-numbered invalid way of the set if one exists. Otherwise it is the least recently used way.
- R10: If the victim is valid and dirty, `wb_valid` is asserted before any burst request. It is held until `wb_ready` is seen. `wb_addr` is the victim line's base address, and `wb_line` holds word offset i in bits [32i+31:32i]. A clean victim produces no write-back.
- R11: While the controller is idle, `mark_valid` takes priority over a request and forces `req_ready` low. A mark whose address is resident sets that line's dirty flag. A mark whose address is not resident changes nothing.
- R12: After reset, `req_ready` is high, `rsp_valid`, `mem_req_valid` and `wb_valid` are low, every entry is invalid and clean, and way i of each set has LRU rank i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 32 | Request byte address |
| req_prefetch | input | 1 | 1 = operand prefetch, 0 = read |
| rsp_valid | output | 1 | One-cycle data return pulse |
| rsp_data | output | 32 | Returned word |
| mark_valid | input | 1 | Neighbouring write path reports a modified line |
| mark_addr | input | 32 | Address of the modified line |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_ready | input | 1 | Burst request accepted |
| mem_req_addr | output | 32 | Word address where the wrapping burst starts |
| mem_rsp_valid | input | 1 | Burst beat present |
| mem_rsp_data | input | 32 | Burst beat data |
| wb_valid | output | 1 | Dirty victim line offered to the write-back buffer |
| wb_ready | input | 1 | Write-back buffer takes the line |
| wb_addr | output | 32 | Victim line base address |
| wb_line | output | 128 | Victim line contents, word i at bits [32i+31:32i] |

## Verification
Misses are issued at word offsets 1 and 3, so both a mid-line wrap and an end-of-line wrap occur. Every word of each filled line is then read back, which distinguishes a correct wrapping fill from a linear or misaligned one. Hit sequences that reorder a full set, followed by misses, show whether the LRU and invalid-first victim choice evicts the intended way, and the same is done with prefetch hits in place of reads. Dirty and clean victims are evicted with the write-back acceptance held back for several cycles, which shows whether the burst waits, whether the right line is handed off, and whether a refill clears the dirty flag.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int WAYS       = 4;
    localparam int SETS       = 16;
    localparam int LINE_WORDS = 4;

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int AGE_W  = WAY_W;
    localparam int LINE_W = LINE_WORDS * DATA_W;

    typedef logic [TAG_W-1:0]       tag_t;
    typedef logic [IDX_W-1:0]       idx_t;
    typedef logic [OFF_W-1:0]       off_t;
    typedef logic [WAY_W-1:0]       way_t;
    typedef logic [AGE_W-1:0]       age_t;
    typedef logic [DATA_W-1:0]      word_t;
    typedef logic [WAYS*AGE_W-1:0]  ages_t;
    typedef logic [LINE_W-1:0]      line_t;

    localparam off_t LAST_OFF = off_t'(LINE_WORDS - 1);
    localparam age_t OLDEST   = age_t'(WAYS - 1);

    typedef struct packed {
        tag_t                tag;
        idx_t                idx;
        off_t                off;
        logic [BYTE_W-1:0]   lsb;
    } addr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FETCH,
        ST_FILL
    } state_e;

    typedef struct packed {
        tag_t tag;
        idx_t idx;
        off_t start;
        way_t way;
        logic pf;
    } miss_t;

    // Rank i for way i: way 0 starts as most recent.
    function automatic ages_t ages_init();
        ages_t r;
        for (int i = 0; i < WAYS; i++) r[i*AGE_W +: AGE_W] = age_t'(i);
        return r;
    endfunction

    // Move way w to rank 0, shifting the younger ways back by one.
    function automatic ages_t ages_touch(ages_t a, way_t w);
        ages_t r;
        age_t  cur;
        cur = a[int'(w)*AGE_W +: AGE_W];
        for (int i = 0; i < WAYS; i++) begin
            age_t ai;
            ai = a[i*AGE_W +: AGE_W];
            if (way_t'(i) == w)  r[i*AGE_W +: AGE_W] = '0;
            else if (ai < cur)   r[i*AGE_W +: AGE_W] = ai + age_t'(1);
            else                 r[i*AGE_W +: AGE_W] = ai;
        end
        return r;
    endfunction

    // Lowest invalid way first, else the oldest way.
    function automatic way_t pick_victim(logic [WAYS-1:0] valid, ages_t a);
        way_t v;
        logic found;
        v = '0;
        found = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!found && !valid[i]) begin
                v = way_t'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < WAYS; i++)
                if (a[i*AGE_W +: AGE_W] == OLDEST) v = way_t'(i);
        end
        return v;
    endfunction

endpackage

// File: rtl/crc_tag_store.sv
module crc_tag_store
    import crc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    // lookup port
    input  idx_t            lk_idx,
    input  tag_t            lk_tag,
    output logic            lk_hit,
    output way_t            lk_way,
    output logic [WAYS-1:0] lk_valid,
    // entry query port
    input  idx_t            q_idx,
    input  way_t            q_way,
    output logic            q_valid,
    output logic            q_dirty,
    output tag_t            q_tag,
    // dirty mark port
    input  logic            mk_en,
    input  idx_t            mk_idx,
    input  tag_t            mk_tag,
    // install port
    input  logic            in_en,
    input  idx_t            in_idx,
    input  way_t            in_way,
    input  tag_t            in_tag
);

    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] dirty_q [SETS];
    tag_t            tag_q   [SETS][WAYS];

    logic [WAYS-1:0] lk_match, mk_match;
    logic            mk_hit;
    way_t            mk_way;

    always_comb begin
        lk_way = '0;
        mk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            lk_match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
            mk_match[w] = valid_q[mk_idx][w] && (tag_q[mk_idx][w] == mk_tag);
            if (lk_match[w]) lk_way = way_t'(w);
            if (mk_match[w]) mk_way = way_t'(w);
        end
    end

    assign lk_hit   = |lk_match;
    assign mk_hit   = |mk_match;
    assign lk_valid = valid_q[lk_idx];
    assign q_valid  = valid_q[q_idx][q_way];
    assign q_dirty  = dirty_q[q_idx][q_way];
    assign q_tag    = tag_q[q_idx][q_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (mk_en && mk_hit) dirty_q[mk_idx][mk_way] <= 1'b1;
            if (in_en) begin
                valid_q[in_idx][in_way] <= 1'b1;
                dirty_q[in_idx][in_way] <= 1'b0;
                tag_q[in_idx][in_way]   <= in_tag;
            end
        end
    end

    // checker state for entry updates
    logic ins_pend, mk_pend;
    idx_t ins_idx_q, mk_idx_q;
    way_t ins_way_q, mk_way_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_pend  <= 1'b0;
            mk_pend   <= 1'b0;
            ins_idx_q <= '0;
            ins_way_q <= '0;
            mk_idx_q  <= '0;
            mk_way_q  <= '0;
        end else begin
            ins_pend  <= in_en;
            ins_idx_q <= in_idx;
            ins_way_q <= in_way;
            mk_pend   <= mk_en && mk_hit;
            mk_idx_q  <= mk_idx;
            mk_way_q  <= mk_way;
        end
    end

    // R6
    install_clean_chk: assert property (@(posedge clk) disable iff (rst)
        ins_pend |-> (valid_q[ins_idx_q][ins_way_q] && !dirty_q[ins_idx_q][ins_way_q]));

    // R11
    mark_sets_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        mk_pend |-> dirty_q[mk_idx_q][mk_way_q]);

endmodule

// File: rtl/crc_lru_store.sv
module crc_lru_store
    import crc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    output ages_t rd_ages,
    input  logic  upd_en,
    input  idx_t  upd_idx,
    input  way_t  upd_way
);

    ages_t ages_q [SETS];

    assign rd_ages = ages_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ages_q[s] <= ages_init();
        end else if (upd_en) begin
            ages_q[upd_idx] <= ages_touch(ages_q[upd_idx], upd_way);
        end
    end

    logic upd_pend;
    idx_t upd_idx_q;
    way_t upd_way_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_pend  <= 1'b0;
            upd_idx_q <= '0;
            upd_way_q <= '0;
        end else begin
            upd_pend  <= upd_en;
            upd_idx_q <= upd_idx;
            upd_way_q <= upd_way;
        end
    end

    // R2
    touched_newest_chk: assert property (@(posedge clk) disable iff (rst)
        upd_pend |-> (ages_q[upd_idx_q][int'(upd_way_q)*AGE_W +: AGE_W] == '0));

endmodule

// File: rtl/crc_line_ram.sv
module crc_line_ram
    import crc_pkg::*;
(
    input  logic  clk,
    // word read
    input  idx_t  rd_idx,
    input  way_t  rd_way,
    input  off_t  rd_off,
    output word_t rd_data,
    // whole-line read
    input  idx_t  ln_idx,
    input  way_t  ln_way,
    output line_t ln_data,
    // word write
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  way_t  wr_way,
    input  off_t  wr_off,
    input  word_t wr_data
);

    localparam int DEPTH = SETS * WAYS * LINE_WORDS;

    word_t mem_q [DEPTH];

    assign rd_data = mem_q[{rd_idx, rd_way, rd_off}];

    for (genvar k = 0; k < LINE_WORDS; k++) begin : g_line
        assign ln_data[k*DATA_W +: DATA_W] = mem_q[{ln_idx, ln_way, off_t'(k)}];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_idx, wr_way, wr_off}] <= wr_data;
    end

endmodule

// File: rtl/cache_read_ctrl.sv
module cache_read_ctrl
    import crc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_prefetch,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    input  logic               mark_valid,
    input  logic [ADDR_W-1:0]  mark_addr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [DATA_W-1:0]  mem_rsp_data,
    output logic               wb_valid,
    input  logic               wb_ready,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [LINE_W-1:0]  wb_line
);

    addr_t rq, mk;
    assign rq = addr_t'(req_addr);
    assign mk = addr_t'(mark_addr);

    logic unused_addr_bits;
    assign unused_addr_bits = ^{rq.lsb, mk.off, mk.lsb};

    state_e state_q;
    miss_t  miss_q;
    off_t   ptr_q;
    off_t   beat_q;
    logic   rsp_v_q;
    word_t  rsp_d_q;

    logic            lk_hit;
    way_t            lk_way;
    logic [WAYS-1:0] lk_valid;
    logic            q_valid, q_dirty;
    tag_t            q_tag;
    ages_t           ages;
    way_t            victim;
    word_t           hit_word;
    line_t           line;

    logic idle, accept, fill_beat, last_beat, evict_dirty;
    logic upd_en;
    idx_t upd_idx;
    way_t upd_way;

    assign idle        = (state_q == ST_IDLE);
    assign req_ready   = idle && !mark_valid;
    assign accept      = req_ready && req_valid;
    assign fill_beat   = (state_q == ST_FILL) && mem_rsp_valid;
    assign last_beat   = fill_beat && (beat_q == LAST_OFF);
    assign evict_dirty = q_valid && q_dirty;
    assign victim      = pick_victim(lk_valid, ages);

    assign upd_en  = (accept && lk_hit) || last_beat;
    assign upd_idx = last_beat ? miss_q.idx : rq.idx;
    assign upd_way = last_beat ? miss_q.way : lk_way;

    crc_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (rq.idx),
        .lk_tag   (rq.tag),
        .lk_hit   (lk_hit),
        .lk_way   (lk_way),
        .lk_valid (lk_valid),
        .q_idx    (miss_q.idx),
        .q_way    (miss_q.way),
        .q_valid  (q_valid),
        .q_dirty  (q_dirty),
        .q_tag    (q_tag),
        .mk_en    (idle && mark_valid),
        .mk_idx   (mk.idx),
        .mk_tag   (mk.tag),
        .in_en    (last_beat),
        .in_idx   (miss_q.idx),
        .in_way   (miss_q.way),
        .in_tag   (miss_q.tag)
    );

    crc_lru_store u_lru (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rq.idx),
        .rd_ages (ages),
        .upd_en  (upd_en),
        .upd_idx (upd_idx),
        .upd_way (upd_way)
    );

    crc_line_ram u_ram (
        .clk     (clk),
        .rd_idx  (rq.idx),
        .rd_way  (lk_way),
        .rd_off  (rq.off),
        .rd_data (hit_word),
        .ln_idx  (miss_q.idx),
        .ln_way  (miss_q.way),
        .ln_data (line),
        .wr_en   (fill_beat),
        .wr_idx  (miss_q.idx),
        .wr_way  (miss_q.way),
        .wr_off  (ptr_q),
        .wr_data (mem_rsp_data)
    );

    assign wb_valid      = (state_q == ST_EVICT) && evict_dirty;
    assign wb_addr       = {q_tag, miss_q.idx, {(OFF_W+BYTE_W){1'b0}}};
    assign wb_line       = line;
    assign mem_req_valid = (state_q == ST_FETCH);
    assign mem_req_addr  = {miss_q.tag, miss_q.idx, miss_q.start, {BYTE_W{1'b0}}};
    assign rsp_valid     = rsp_v_q;
    assign rsp_data      = rsp_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            miss_q  <= '0;
            ptr_q   <= '0;
            beat_q  <= '0;
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            rsp_v_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (lk_hit) begin
                            if (!req_prefetch) begin
                                rsp_v_q <= 1'b1;
                                rsp_d_q <= hit_word;
                            end
                        end else begin
                            miss_q.tag   <= rq.tag;
                            miss_q.idx   <= rq.idx;
                            miss_q.start <= rq.off;
                            miss_q.way   <= victim;
                            miss_q.pf    <= req_prefetch;
                            state_q      <= ST_EVICT;
                        end
                    end
                end
                ST_EVICT: begin
                    if (!evict_dirty || wb_ready) state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_req_ready) begin
                        state_q <= ST_FILL;
                        ptr_q   <= miss_q.start;
                        beat_q  <= '0;
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        ptr_q  <= ptr_q + off_t'(1);
                        beat_q <= beat_q + off_t'(1);
                        if (beat_q == '0 && !miss_q.pf) begin
                            rsp_v_q <= 1'b1;
                            rsp_d_q <= mem_rsp_data;
                        end
                        if (last_beat) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    miss_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !lk_hit) |=> !req_ready);

    // R5
    crit_word_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_beat && beat_q == '0 && !miss_q.pf) |=>
            (rsp_valid && rsp_data == $past(mem_rsp_data)));

    // R8
    prefetch_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_beat && miss_q.pf) |=> !rsp_valid);

    // R10
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && !mem_req_valid && $stable(wb_addr)));

endmodule

// File: tb/sim_cache_read_ctrl.sv
`timescale 1ns/1ps
module sim_cache_read_ctrl;
    import crc_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [31:0]        req_addr = '0;
    logic               req_prefetch = 1'b0;
    logic               rsp_valid;
    logic [31:0]        rsp_data;
    logic               mark_valid = 1'b0;
    logic [31:0]        mark_addr = '0;
    logic               mem_req_valid;
    logic               mem_req_ready = 1'b0;
    logic [31:0]        mem_req_addr;
    logic               mem_rsp_valid = 1'b0;
    logic [31:0]        mem_rsp_data = '0;
    logic               wb_valid;
    logic               wb_ready = 1'b0;
    logic [31:0]        wb_addr;
    logic [127:0]       wb_line;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int fetch_cnt = 0, rsp_cnt = 0, wb_cnt = 0;
    int beat0_cyc = 0, rsp_cyc = 0, fetch_cyc = 0, wb_cyc = 0;
    int hold_left = 0;
    bit mem_during_wb = 1'b0;
    logic [31:0]  cap_addr = '0, rsp_last = '0, wb_addr_cap = '0;
    logic [127:0] wb_line_cap = '0;

    always #4 clk = ~clk;

    cache_read_ctrl u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_prefetch(req_prefetch), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mark_valid(mark_valid), .mark_addr(mark_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_line(wb_line)
    );

    function automatic logic [31:0] mdat(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
    endfunction

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // external memory: wrapping 4-beat burst
    initial forever begin
        @(negedge clk);
        if (mem_req_valid && !mem_req_ready) begin
            cap_addr = mem_req_addr;
            fetch_cnt++;
            fetch_cyc = cyc;
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            for (int k = 0; k < 4; k++) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mdat({cap_addr[31:4], cap_addr[3:2] + 2'(k), 2'b00});
                if (k == 0) beat0_cyc = cyc;
                @(negedge clk);
            end
            mem_rsp_valid = 1'b0;
        end
    end

    // write-back buffer with programmable hold
    initial forever begin
        @(negedge clk);
        if (wb_valid && !wb_ready) begin
            if (hold_left > 0) begin
                hold_left--;
                if (mem_req_valid) mem_during_wb = 1'b1;
            end else begin
                wb_ready    = 1'b1;
                wb_cnt++;
                wb_cyc      = cyc;
                wb_addr_cap = wb_addr;
                wb_line_cap = wb_line;
                @(negedge clk);
                wb_ready = 1'b0;
            end
        end
    end

    // response monitor
    initial forever begin
        @(negedge clk);
        if (rsp_valid) begin
            rsp_cnt++;
            rsp_last = rsp_data;
            rsp_cyc  = cyc;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic do_access(input logic [31:0] a, input bit pf, input bit exp_hit,
                             input string r);
        int f0, r0, t;
        bit busy;
        f0 = fetch_cnt;
        r0 = rsp_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_prefetch = pf;
        t = 0;
        while (!req_ready && t < 50) begin @(negedge clk); t++; end
        @(negedge clk);
        req_valid = 1'b0;
        busy = !req_ready;
        t = 0;
        while (!req_ready && t < 100) begin @(negedge clk); t++; end
        @(negedge clk);
        chk(fetch_cnt == f0 + (exp_hit ? 0 : 1), r, "burst count", fetch_cnt, f0 + (exp_hit ? 0 : 1));
        chk(rsp_cnt == r0 + (pf ? 0 : 1), r, "response count", rsp_cnt, r0 + (pf ? 0 : 1));
        if (!pf)
            chk(rsp_last == mdat({a[31:2], 2'b00}), r, "response data", rsp_last, mdat({a[31:2], 2'b00}));
        if (!exp_hit) begin
            chk(busy, "R3", "req_ready low during miss", busy, 1);
            chk(cap_addr == {a[31:2], 2'b00}, "R3", "burst address", cap_addr, {a[31:2], 2'b00});
            if (!pf)
                chk(rsp_cyc == beat0_cyc + 1, "R5", "critical word cycle", rsp_cyc - beat0_cyc, 1);
        end
    endtask

    task automatic do_mark(input logic [31:0] a);
        @(negedge clk);
        mark_valid = 1'b1; mark_addr = a;
        #1;
        chk(!req_ready, "R11", "req_ready during mark", req_ready, 0);
        @(negedge clk);
        mark_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(req_ready === 1'b1, "R12", "req_ready", req_ready, 1);
        chk(rsp_valid === 1'b0, "R12", "rsp_valid", rsp_valid, 0);
        chk(mem_req_valid === 1'b0, "R12", "mem_req_valid", mem_req_valid, 0);
        chk(wb_valid === 1'b0, "R12", "wb_valid", wb_valid, 0);
    endtask

    task automatic t_fill_wrap();
        do_access(32'h0000_1004, 0, 0, "R5");
        do_access(32'h0000_1008, 0, 1, "R4");
        do_access(32'h0000_100C, 0, 1, "R4");
        do_access(32'h0000_1000, 0, 1, "R4");
        do_access(32'h0000_1004, 0, 1, "R1");
    endtask

    task automatic t_victim();
        // set 1; fills go to invalid ways without evicting each other
        do_access(32'h0002_0010, 0, 0, "R9");
        do_access(32'h0003_0010, 0, 0, "R9");
        do_access(32'h0004_0010, 0, 0, "R9");
        do_access(32'h0005_0010, 0, 0, "R9");
        do_access(32'h0002_0010, 0, 1, "R9");
        do_access(32'h0003_0014, 0, 1, "R9");
        do_access(32'h0004_0018, 0, 1, "R9");
        do_access(32'h0005_001C, 0, 1, "R9");
        do_access(32'h0002_0010, 0, 1, "R2");   // oldest way becomes newest
        do_access(32'h0006_0010, 0, 0, "R2");   // evicts 0x0003 line
        do_access(32'h0002_0010, 0, 1, "R2");
        do_access(32'h0004_0010, 0, 1, "R2");
        do_access(32'h0003_0010, 0, 0, "R2");
        do_access(32'h0006_0010, 0, 1, "R6");
    endtask

    task automatic t_prefetch();
        do_access(32'h0011_0020, 0, 0, "R9");
        do_access(32'h0012_0020, 0, 0, "R9");
        do_access(32'h0013_0020, 0, 0, "R9");
        do_access(32'h0014_0020, 0, 0, "R9");
        do_access(32'h0011_0020, 1, 1, "R7");   // prefetch hit on oldest
        do_access(32'h0015_0020, 0, 0, "R7");   // must evict 0x0012
        do_access(32'h0011_0024, 0, 1, "R7");
        do_access(32'h0012_0020, 0, 0, "R7");
        do_access(32'h0020_003C, 1, 0, "R8");   // wrap from offset 3
        do_access(32'h0020_003C, 0, 1, "R8");
        do_access(32'h0020_0030, 0, 1, "R4");
        do_access(32'h0020_0034, 0, 1, "R4");
        do_access(32'h0020_0038, 0, 1, "R4");
    endtask

    task automatic t_dirty();
        int w0;
        logic [127:0] exp_line;
        do_access(32'h0001_0040, 0, 0, "R9");
        do_access(32'h0002_0040, 0, 0, "R9");
        do_access(32'h0003_0040, 0, 0, "R9");
        do_access(32'h0004_0040, 0, 0, "R9");
        do_mark(32'h0005_0048);                  // not resident: no effect
        do_mark(32'h0001_0044);                  // resident: becomes dirty
        w0 = wb_cnt;
        hold_left = 5;
        mem_during_wb = 1'b0;
        do_access(32'h0005_0048, 0, 0, "R10");
        for (int i = 0; i < 4; i++)
            exp_line[32*i +: 32] = mdat(32'h0001_0040 + 32'(4*i));
        chk(wb_cnt == w0 + 1, "R10", "write-back count", wb_cnt, w0 + 1);
        chk(wb_addr_cap == 32'h0001_0040, "R10", "write-back address", wb_addr_cap, 32'h0001_0040);
        chk(wb_line_cap == exp_line, "R10", "write-back line", wb_line_cap, exp_line);
        chk(!mem_during_wb, "R10", "burst during held write-back", mem_during_wb, 0);
        chk(fetch_cyc > wb_cyc, "R10", "burst after write-back", fetch_cyc, wb_cyc + 1);
        // evict the remaining lines, including the refilled one: all clean
        do_access(32'h0006_0040, 0, 0, "R11");
        do_access(32'h0007_0040, 0, 0, "R11");
        do_access(32'h0008_0040, 0, 0, "R11");
        do_access(32'h0009_0040, 0, 0, "R6");
        chk(wb_cnt == w0 + 1, "R6", "clean victims write back", wb_cnt, w0 + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_wrap();
        t_victim();
        t_prefetch();
        t_dirty();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule